// File: doc/BRIEF.md
# Fare Remaining-Amount Display

This block takes the credit code of a ticket-vending controller and drives two seven-segment digits with the amount the customer still owes. The fare is fixed at 15 units. Coins add credit in steps of 5, so the value on the display can only be 15, 10, 5 or 0. The block runs on the controller's clock. It samples the credit code on every rising edge and registers the segment patterns for a tens digit and a units digit.

Inside, a mapping stage turns each credit code into an owed amount and clamps overpayment to zero. A splitter then breaks that amount into decimal tens and units. Two glyph encoders produce the segment patterns, and a register stage holds them.

Two build-time options change what the digits look like. One blanks a leading zero in the tens place. The other inverts every segment line for common-anode displays.

The credit codes this block handles, named in its package, are:

| Code | Name | Credit |
|---|---|---|
| 000 | `CR_NONE` | 0 |
| 001 | `CR_FIVE` | 5 |
| 010 | `CR_TEN` | 10 |
| 011 | `CR_PAID` | 15 |
| 100 | `CR_OVER` | 20 |

Codes 101 to 111 are unused.

The controller moves through these codes as follows:
- `CR_NONE` to `CR_FIVE` or `CR_TEN` when a coin is inserted.
- `CR_FIVE` to `CR_TEN` or `CR_PAID`.
- `CR_TEN` to `CR_PAID` or `CR_OVER`.
- `CR_PAID` and `CR_OVER` return to `CR_NONE` on the next clock.
- Unused codes also fall back to `CR_NONE`.

Top module: `fare_display`

## Requirements
- R1: Owed amount by credit code: 000 shows 15, 001 shows 10, 010 shows 5, 011 shows 0, and 100 (overpayment) shows 0, never a negative value.
- R2: Unused codes 101, 110 and 111 show the full fare of 15.
- R3: Each digit output is 7 bits in the order {g,f,e,d,c,b,a}, with bit 0 = segment a, active-high by default. The glyph for 0 is 7'h3F, for 1 is 7'h06 and for 5 is 7'h6D.
- R4: With leading-zero blanking off (the default), an amount below 10 drives the 0 glyph (7'h3F) on the tens digit, so 5 shows as "05" and 0 as "00".
- R5: With leading-zero blanking on, the tens digit is all segments off whenever the tens value is zero. The units digit is never blanked.
- R6: With the active-low option on, every segment bit of both digits is the inverse of its active-high value. Under blanking, an off digit reads 7'h7F.
- R7: Outputs are registered. A credit code present at a rising edge appears on the outputs after that edge, and the outputs do not change between edges.
- R8: While the synchronous reset is high at a rising edge, the outputs show 15 after that edge, whatever the credit code.
- R9: A dispense sequence shows "00" in the cycle after code 011 or 100 is sampled. When code 000 follows, the display returns to "15" one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the vending controller |
| rst | input | 1 | Synchronous reset, active high |
| credit_code | input | 3 | Credit code from the controller |
| seg_tens | output | 7 | Tens digit segments {g,f,e,d,c,b,a} |
| seg_units | output | 7 | Units digit segments {g,f,e,d,c,b,a} |

## Verification
The bench builds two copies of the block side by side, driven by the same credit code and reset. One copy uses the defaults: no blanking, active-high segments. The other turns on both leading-zero blanking and active-low output. Between them, every code is seen as a plain "05" or "00" and also as an inverted display with a dark tens digit. This brings both generate variants of the glyph encoder within reach in a single run.

// File: rtl/fare_display_pkg.sv
package fare_display_pkg;

    localparam int SEG_W   = 7;
    localparam int DIGIT_W = 4;

    typedef enum logic [2:0] {
        CR_NONE = 3'b000,
        CR_FIVE = 3'b001,
        CR_TEN  = 3'b010,
        CR_PAID = 3'b011,
        CR_OVER = 3'b100
    } credit_e;

    typedef logic [SEG_W-1:0]   seg_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Active-high glyph, bit order {g,f,e,d,c,b,a}
    function automatic seg_t glyph_of(input digit_t d);
        seg_t g;
        unique case (d)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = 7'h40;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/fare_amount_map.sv
module fare_amount_map
    import fare_display_pkg::*;
#(
    parameter int PRICE    = 15,
    parameter int STEP     = 5,
    parameter int TOP_CODE = 4,
    parameter int CODE_W   = 3,
    localparam int AMT_W   = $clog2(PRICE + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [AMT_W-1:0]  owed_o
);

    localparam int WIDE_W = 16;

    logic [WIDE_W-1:0] credit;
    logic              legal;

    always_comb begin
        legal  = (WIDE_W'(code_i) <= WIDE_W'(TOP_CODE));
        credit = legal ? WIDE_W'(code_i) * WIDE_W'(STEP) : '0;
        if (credit >= WIDE_W'(PRICE)) begin
            owed_o = '0;
        end else begin
            owed_o = AMT_W'(WIDE_W'(PRICE) - credit);
        end
    end

endmodule

// File: rtl/fare_decimal_split.sv
module fare_decimal_split
    import fare_display_pkg::*;
#(
    parameter int AMT_W = 4
) (
    input  logic [AMT_W-1:0] amount_i,
    output digit_t           tens_o,
    output digit_t           units_o
);

    localparam int WIDE_W = 8;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide    = WIDE_W'(amount_i);
        tens_o  = DIGIT_W'(wide / WIDE_W'(10));
        units_o = DIGIT_W'(wide % WIDE_W'(10));
    end

endmodule

// File: rtl/fare_seg_encode.sv
module fare_seg_encode
    import fare_display_pkg::*;
#(
    parameter bit BLANK_ZERO = 1'b0,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  digit_t digit_i,
    output seg_t   seg_o
);

    seg_t lit;

    generate
        if (BLANK_ZERO) begin : g_blank
            assign lit = (digit_i == '0) ? '0 : glyph_of(digit_i);
        end else begin : g_plain
            assign lit = glyph_of(digit_i);
        end

        if (ACTIVE_LOW) begin : g_low
            assign seg_o = ~lit;
        end else begin : g_high
            assign seg_o = lit;
        end
    endgenerate

endmodule

// File: rtl/fare_display.sv
module fare_display
    import fare_display_pkg::*;
#(
    parameter int PRICE           = 15,
    parameter int STEP            = 5,
    parameter int TOP_CODE        = 4,
    parameter int CODE_W          = 3,
    parameter bit BLANK_LEAD_ZERO = 1'b0,
    parameter bit SEG_ACTIVE_LOW  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] credit_code,
    output logic [6:0]        seg_tens,
    output logic [6:0]        seg_units
);

    localparam int AMT_W  = $clog2(PRICE + 1);
    localparam int N_DIG  = 2;

    logic [AMT_W-1:0]              owed;
    logic [AMT_W-1:0]              shown;
    digit_t [N_DIG-1:0]            digit;
    seg_t   [N_DIG-1:0]            seg_next;

    fare_amount_map #(
        .PRICE    (PRICE),
        .STEP     (STEP),
        .TOP_CODE (TOP_CODE),
        .CODE_W   (CODE_W)
    ) u_map (
        .code_i (credit_code),
        .owed_o (owed)
    );

    // Reset path loads the full fare through the same encoders
    assign shown = rst ? AMT_W'(PRICE) : owed;

    fare_decimal_split #(
        .AMT_W (AMT_W)
    ) u_split (
        .amount_i (shown),
        .tens_o   (digit[1]),
        .units_o  (digit[0])
    );

    // Index 0 = units (never blanked), index 1 = tens
    generate
        for (genvar gi = 0; gi < N_DIG; gi++) begin : g_digit
            fare_seg_encode #(
                .BLANK_ZERO ((gi == 1) ? BLANK_LEAD_ZERO : 1'b0),
                .ACTIVE_LOW (SEG_ACTIVE_LOW)
            ) u_enc (
                .digit_i (digit[gi]),
                .seg_o   (seg_next[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        seg_units <= seg_next[0];
        seg_tens  <= seg_next[1];
    end

endmodule

// File: rtl/fare_display_chk.sv
module fare_display_chk
    import fare_display_pkg::*;
#(
    parameter int CODE_W          = 3,
    parameter bit BLANK_LEAD_ZERO = 1'b0,
    parameter bit SEG_ACTIVE_LOW  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] credit_code,
    input logic [6:0]        seg_tens,
    input logic [6:0]        seg_units
);

    function automatic seg_t vis(input seg_t p);
        return SEG_ACTIVE_LOW ? ~p : p;
    endfunction

    localparam seg_t G0 = 7'h3F;
    localparam seg_t G1 = 7'h06;
    localparam seg_t G5 = 7'h6D;

    seg_t tens_zero;
    assign tens_zero = BLANK_LEAD_ZERO ? vis(7'h00) : vis(G0);

    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b1;
    end

    // R8: reset shows the full fare
    p_reset_fare_r8: assert property (@(posedge clk)
        rst |=> (seg_tens == vis(G1) && seg_units == vis(G5)));

    // R1 / R9: paid or overpaid shows zero owed
    p_paid_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (credit_code == 3'd3 || credit_code == 3'd4)
        |=> (seg_tens == tens_zero && seg_units == vis(G0)));

    // R2: unused codes show the fare
    p_unused_fare_r2: assert property (@(posedge clk) disable iff (rst)
        (credit_code >= 3'd5) |=> (seg_tens == vis(G1) && seg_units == vis(G5)));

    // R4 / R5: partial credit of 10 leaves a zero tens digit
    p_tens_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (credit_code == 3'd2) |=> (seg_tens == tens_zero && seg_units == vis(G5)));

    // R3: units digit only ever shows 0 or 5
    p_units_legal_r3: assert property (@(posedge clk) disable iff (rst)
        started |-> (seg_units == vis(G0) || seg_units == vis(G5)));

    // R7: outputs follow the previous sampled code only
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (started && $stable(credit_code)) |=> $stable(seg_units));

endmodule

bind fare_display fare_display_chk #(
    .CODE_W          (CODE_W),
    .BLANK_LEAD_ZERO (BLANK_LEAD_ZERO),
    .SEG_ACTIVE_LOW  (SEG_ACTIVE_LOW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .credit_code (credit_code),
    .seg_tens    (seg_tens),
    .seg_units   (seg_units)
);

// File: tb/fare_display_bench.sv
module fare_display_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] credit_code;
    logic [6:0] d_tens, d_units, l_tens, l_units;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #4 clk = ~clk;

    fare_display u_fare_display (
        .clk (clk), .rst (rst), .credit_code (credit_code),
        .seg_tens (d_tens), .seg_units (d_units)
    );

    fare_display #(.BLANK_LEAD_ZERO(1'b1), .SEG_ACTIVE_LOW(1'b1)) u_fare_display_lo (
        .clk (clk), .rst (rst), .credit_code (credit_code),
        .seg_tens (l_tens), .seg_units (l_units)
    );

    function automatic int exp_amt(input logic [2:0] c);
        case (c)
            3'd0:      return 15;
            3'd1:      return 10;
            3'd2:      return 5;
            3'd3, 3'd4: return 0;
            default:   return 15;
        endcase
    endfunction

    function automatic logic [6:0] glyph(input int d);
        case (d)
            0:       return 7'h3F;
            1:       return 7'h06;
            5:       return 7'h6D;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [6:0] exp_tens(input int amt, input bit blank, input bit low);
        logic [6:0] p;
        p = (blank && (amt / 10) == 0) ? 7'h00 : glyph(amt / 10);
        return low ? ~p : p;
    endfunction

    function automatic logic [6:0] exp_units(input int amt, input bit low);
        logic [6:0] p;
        p = glyph(amt % 10);
        return low ? ~p : p;
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_amt(input string tag, input int amt);
        check({tag, " default tens"},  d_tens,  exp_tens(amt, 1'b0, 1'b0));
        check({tag, " default units"}, d_units, exp_units(amt, 1'b0));
        check({tag, " blank/low tens"},  l_tens,  exp_tens(amt, 1'b1, 1'b1));
        check({tag, " blank/low units"}, l_units, exp_units(amt, 1'b1));
    endtask

    // apply code, clock once, sample 1 ns after the edge
    task automatic step(input logic [2:0] c);
        credit_code = c;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        credit_code = 3'd3;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check_amt("R8 reset shows fare despite code 011", 15);

        rst = 1'b0;
        // R1 / R2 / R3 / R4 / R5 / R6: every code directed
        for (int c = 0; c < 8; c++) begin
            step(3'(c));
            check_amt($sformatf("R1 R2 R3 R4 R5 R6 code %0d", c), exp_amt(3'(c)));
        end

        // R7: code change not visible before the edge
        step(3'd0);
        credit_code = 3'd3;
        #2;
        check_amt("R7 held before edge", 15);
        @(posedge clk);
        #1;
        check_amt("R7 updated after edge", 0);

        // R9: dispense then back to start, for both paid codes
        step(3'd1);
        step(3'd3);
        check_amt("R9 paid shows 00", 0);
        step(3'd0);
        check_amt("R9 returns to 15", 15);
        step(3'd2);
        step(3'd4);
        check_amt("R9 overpaid shows 00", 0);
        step(3'd0);
        check_amt("R9 overpaid returns to 15", 15);

        // R8: mid-run reset
        step(3'd2);
        rst = 1'b1;
        step(3'd2);
        check_amt("R8 mid-run reset", 15);
        rst = 1'b0;

        // random codes
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            c = 3'($urandom % 8);
            step(c);
            check_amt("R1 R2 random", exp_amt(c));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule